// File: doc/BRIEF.md
# Outbound Address Translation Unit

This block rewrites the addresses of outgoing requests. It takes a 64-bit address in the local memory domain and returns the matching 64-bit address in the bus domain. It also returns a transaction type and a flag that says whether any window matched. The block holds a small set of translation windows. Each window has a 64-bit source base, the low 32 bits of its last address, a 64-bit target, a type code and an enable bit.

Software never addresses a window directly. It first writes a selector word that names a window index and a direction. All later register writes and reads then act on that window. A window takes part in translation only once its enable bit is set.

The datapath compares the request against every window in parallel. When several windows match, the lowest-numbered enabled one wins. The result appears one clock after the request.

Two small state machines run the block:
- Response machine, with states `OUT_IDLE`, `OUT_HIT` and `OUT_MISS`. Every state moves to `OUT_HIT` when a request arrives and a window matches. It moves to `OUT_MISS` when a request arrives and no window matches. It moves to `OUT_IDLE` when no request is presented.
- Read machine, with states `RD_IDLE` and `RD_RESP`. Every state moves to `RD_RESP` when a read strobe is seen, and to `RD_IDLE` otherwise.

Top module: `outbound_atu`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_hit` and `cfg_rvalid` are 0. Every window is disabled and reads back 0, so a request is passed through unchanged.
- R2: Register word offsets are: 0 = selector, 1 = source base low, 2 = source base high, 3 = limit, 4 = target low, 5 = target high, 6 = type, 7 = enable. The selector holds the window index in bits [7:0] and the direction in bit 31 (0 = outbound). Writes to offsets 1 to 7 go to the window that the selector names. The selector reads back as {bit31, 23 zeros, bits[7:0]}.
- R3: When the selector has bit 31 set, or names an index of NUM_REGIONS or more, writes to offsets 1 to 7 change no window and reads of offsets 1 to 7 return 0.
- R4: A read strobe gives `cfg_rvalid` = 1 together with the addressed word on the next cycle. The type word returns only its low 5 bits. The enable word returns only bit 0.
- R5: A window whose enable bit (bit 0 of offset 7) is 0 never matches, even for an address inside its range.
- R6: A window matches only when all three hold: the address is at least its 64-bit base, the address's low 32 bits are at most its limit, and the address's high 32 bits equal the base's high word. Both end points of the range match. Base−1 and limit+1 do not.
- R7: On a match, the output address is target + (address − base), modulo 2^64. `rsp_type` is that window's 5-bit type.
- R8: When several enabled windows match, the lowest-numbered one supplies the address and the type.
- R9: When no window matches, `rsp_hit` = 0, `rsp_addr` equals the request address and `rsp_type` = 0.
- R10: A request accepted on one rising edge gives its result, with `rsp_valid` = 1, after the next rising edge. Back-to-back requests give back-to-back results. A cycle without `req_valid` gives `rsp_valid` = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_re` |
| cfg_rdata | output | 32 | Read data |
| req_valid | input | 1 | Request address valid |
| req_addr | input | 64 | Local-domain request address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | 64 | Bus-domain (or passed-through) address |
| rsp_type | output | 5 | Transaction type of the winning window, 0 on a miss |
| rsp_hit | output | 1 | 1 when a window matched |

## Verification
The assertions assume that `req_valid`, `cfg_re` and `cfg_we` are held low during reset. They also assume that nothing is read from or written to the register port in the same cycle as a selector change that the access depends on. The bench drives every input on the falling edge. It issues each register access as its own one-cycle strobe and never overlaps a request with a write that would alter the window that request uses. It holds the request strobe low while resetting, and it samples results on the falling edge after the producing rising edge.

// File: rtl/atu_pkg.sv
package atu_pkg;

    parameter int unsigned ATU_TYPE_W = 5;
    parameter int unsigned ATU_ADDR_W = 64;

    typedef enum logic [2:0] {
        OFF_SELECT  = 3'd0,
        OFF_BASE_LO = 3'd1,
        OFF_BASE_HI = 3'd2,
        OFF_LIMIT   = 3'd3,
        OFF_TGT_LO  = 3'd4,
        OFF_TGT_HI  = 3'd5,
        OFF_TYPE    = 3'd6,
        OFF_ENABLE  = 3'd7
    } cfg_off_e;

    typedef struct packed {
        logic [ATU_ADDR_W-1:0] base;
        logic [31:0]           limit;
        logic [ATU_ADDR_W-1:0] target;
        logic [ATU_TYPE_W-1:0] typ;
        logic                  en;
    } window_t;

endpackage

// File: rtl/atu_region_file.sv
module atu_region_file
    import atu_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic                      cfg_re,
    input  logic [2:0]                cfg_addr,
    input  logic [31:0]               cfg_wdata,
    output logic                      cfg_rvalid,
    output logic [31:0]               cfg_rdata,
    output window_t [NUM_REGIONS-1:0] win_o
);

    localparam int unsigned IDX_W   = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
    localparam logic [7:0]  WIN_CNT = 8'(NUM_REGIONS);

    typedef enum logic {RD_IDLE, RD_RESP} rd_state_e;

    rd_state_e                 rd_state_q, rd_state_d;
    logic                      sel_dir_q;
    logic [7:0]                sel_idx_q;
    window_t [NUM_REGIONS-1:0] win_q;
    logic                      sel_ok;
    logic [IDX_W-1:0]          sel;
    cfg_off_e                  off;
    logic [31:0]               rd_word;
    logic [31:0]               rdata_q;

    assign off    = cfg_off_e'(cfg_addr);
    assign sel_ok = !sel_dir_q && (sel_idx_q < WIN_CNT);
    assign sel    = sel_idx_q[IDX_W-1:0];
    assign win_o  = win_q;

    // register writes through the selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_dir_q <= 1'b0;
            sel_idx_q <= '0;
            win_q     <= '0;
        end else if (cfg_we) begin
            if (off == OFF_SELECT) begin
                sel_dir_q <= cfg_wdata[31];
                sel_idx_q <= cfg_wdata[7:0];
            end else if (sel_ok) begin
                unique case (off)
                    OFF_BASE_LO: win_q[sel].base[31:0]    <= cfg_wdata;
                    OFF_BASE_HI: win_q[sel].base[63:32]   <= cfg_wdata;
                    OFF_LIMIT:   win_q[sel].limit         <= cfg_wdata;
                    OFF_TGT_LO:  win_q[sel].target[31:0]  <= cfg_wdata;
                    OFF_TGT_HI:  win_q[sel].target[63:32] <= cfg_wdata;
                    OFF_TYPE:    win_q[sel].typ           <= cfg_wdata[ATU_TYPE_W-1:0];
                    OFF_ENABLE:  win_q[sel].en            <= cfg_wdata[0];
                    default:     ;
                endcase
            end
        end
    end

    // read word selection
    always_comb begin
        rd_word = '0;
        if (off == OFF_SELECT) begin
            rd_word = {sel_dir_q, 23'd0, sel_idx_q};
        end else if (sel_ok) begin
            unique case (off)
                OFF_BASE_LO: rd_word = win_q[sel].base[31:0];
                OFF_BASE_HI: rd_word = win_q[sel].base[63:32];
                OFF_LIMIT:   rd_word = win_q[sel].limit;
                OFF_TGT_LO:  rd_word = win_q[sel].target[31:0];
                OFF_TGT_HI:  rd_word = win_q[sel].target[63:32];
                OFF_TYPE:    rd_word[ATU_TYPE_W-1:0] = win_q[sel].typ;
                OFF_ENABLE:  rd_word[0] = win_q[sel].en;
                default:     rd_word = '0;
            endcase
        end
    end

    // read machine: next state
    always_comb begin
        rd_state_d = rd_state_q;
        unique case (rd_state_q)
            RD_IDLE: rd_state_d = cfg_re ? RD_RESP : RD_IDLE;
            RD_RESP: rd_state_d = cfg_re ? RD_RESP : RD_IDLE;
            default: rd_state_d = RD_IDLE;
        endcase
    end

    // read machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) rd_state_q <= RD_IDLE;
        else        rd_state_q <= rd_state_d;
    end

    // read machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (cfg_re) rdata_q <= rd_word;
        else             rdata_q <= '0;
    end

    assign cfg_rvalid = (rd_state_q == RD_RESP);
    assign cfg_rdata  = rdata_q;

    AST_BLOCKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (off != OFF_SELECT) && (sel_dir_q || (sel_idx_q >= WIN_CNT))) |=> $stable(win_q)); // R3
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_re |=> cfg_rvalid); // R4
    AST_READ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_re |=> !cfg_rvalid); // R4

endmodule

// File: rtl/atu_region_match.sv
module atu_region_match
    import atu_pkg::*;
(
    input  window_t               win,
    input  logic [ATU_ADDR_W-1:0] addr,
    output logic                  match,
    output logic [ATU_ADDR_W-1:0] xlat
);

    logic above_base;
    logic below_limit;
    logic same_upper;

    always_comb begin
        above_base  = (addr >= win.base);
        below_limit = (addr[31:0] <= win.limit);
        same_upper  = (addr[63:32] == win.base[63:32]);
        match       = win.en && above_base && below_limit && same_upper;
        xlat        = win.target + (addr - win.base);
    end

endmodule

// File: rtl/atu_priority_pick.sv
module atu_priority_pick
    import atu_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic [NUM_REGIONS-1:0]                 match,
    input  logic [NUM_REGIONS-1:0][ATU_ADDR_W-1:0] xlat,
    input  logic [NUM_REGIONS-1:0][ATU_TYPE_W-1:0] typ,
    output logic                                   any_hit,
    output logic [ATU_ADDR_W-1:0]                  pick_addr,
    output logic [ATU_TYPE_W-1:0]                  pick_type
);

    // scan from the top so the lowest matching index is written last
    always_comb begin
        any_hit   = 1'b0;
        pick_addr = '0;
        pick_type = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                any_hit   = 1'b1;
                pick_addr = xlat[i];
                pick_type = typ[i];
            end
        end
    end

endmodule

// File: rtl/outbound_atu.sv
module outbound_atu
    import atu_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic                  cfg_re,
    input  logic [2:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic                  cfg_rvalid,
    output logic [31:0]           cfg_rdata,
    input  logic                  req_valid,
    input  logic [63:0]           req_addr,
    output logic                  rsp_valid,
    output logic [63:0]           rsp_addr,
    output logic [ATU_TYPE_W-1:0] rsp_type,
    output logic                  rsp_hit
);

    typedef enum logic [1:0] {OUT_IDLE, OUT_HIT, OUT_MISS} out_state_e;

    window_t [NUM_REGIONS-1:0]              win_w;
    logic [NUM_REGIONS-1:0]                 match_w;
    logic [NUM_REGIONS-1:0][ATU_ADDR_W-1:0] xlat_w;
    logic [NUM_REGIONS-1:0][ATU_TYPE_W-1:0] typ_w;
    logic                                   pick_hit;
    logic [ATU_ADDR_W-1:0]                  pick_addr;
    logic [ATU_TYPE_W-1:0]                  pick_type;
    out_state_e                             out_state_q, out_state_d;
    logic [ATU_ADDR_W-1:0]                  rsp_addr_q;
    logic [ATU_TYPE_W-1:0]                  rsp_type_q;

    atu_region_file #(.NUM_REGIONS(NUM_REGIONS)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rvalid(cfg_rvalid),
        .cfg_rdata (cfg_rdata),
        .win_o     (win_w)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        atu_region_match i_match (
            .win  (win_w[g]),
            .addr (req_addr),
            .match(match_w[g]),
            .xlat (xlat_w[g])
        );
        assign typ_w[g] = win_w[g].typ;

        AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            !win_w[g].en |-> !match_w[g]); // R5
    end

    atu_priority_pick #(.NUM_REGIONS(NUM_REGIONS)) i_pick (
        .match    (match_w),
        .xlat     (xlat_w),
        .typ      (typ_w),
        .any_hit  (pick_hit),
        .pick_addr(pick_addr),
        .pick_type(pick_type)
    );

    // response machine: next state
    always_comb begin
        out_state_d = out_state_q;
        unique case (out_state_q)
            OUT_IDLE, OUT_HIT, OUT_MISS: begin
                if (!req_valid)    out_state_d = OUT_IDLE;
                else if (pick_hit) out_state_d = OUT_HIT;
                else               out_state_d = OUT_MISS;
            end
            default: out_state_d = OUT_IDLE;
        endcase
    end

    // response machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) out_state_q <= OUT_IDLE;
        else        out_state_q <= out_state_d;
    end

    // response machine: outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_addr_q <= '0;
            rsp_type_q <= '0;
        end else if (req_valid) begin
            rsp_addr_q <= pick_hit ? pick_addr : req_addr;
            rsp_type_q <= pick_hit ? pick_type : '0;
        end
    end

    assign rsp_valid = (out_state_q != OUT_IDLE);
    assign rsp_hit   = (out_state_q == OUT_HIT);
    assign rsp_addr  = rsp_addr_q;
    assign rsp_type  = rsp_type_q;

    AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_RESULT_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_MISS_PASSES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !(|match_w)) |=> (rsp_addr == $past(req_addr))); // R9
    AST_MISS_TYPE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_type == '0)); // R9

endmodule

// File: tb/test_outbound_atu.sv
module test_outbound_atu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_rvalid;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_addr;
    logic [4:0]  rsp_type;
    logic        rsp_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    outbound_atu i_outbound_atu (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_hit(rsp_hit)
    );

    localparam logic [63:0] B0 = 64'h0000_0001_1000_0000;
    localparam logic [31:0] L0 = 32'h1000_FFFF;
    localparam logic [63:0] T0 = 64'h0000_0020_0000_0000;
    localparam logic [63:0] B1 = 64'h0000_0000_5000_0000;
    localparam logic [63:0] T1 = 64'h0000_0000_7000_0000;
    localparam logic [63:0] T2 = 64'h0000_0030_0000_0000;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] off, input logic [31:0] exp, input string tag);
        cfg_re = 1'b1; cfg_addr = off;
        @(negedge clk);
        cfg_re = 1'b0;
        check(cfg_rvalid == 1'b1, {tag, " rvalid"}, 64'(cfg_rvalid), 64'd1);
        check(cfg_rdata == exp, {tag, " rdata"}, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic xl_chk(input logic [63:0] a, input bit ehit, input logic [63:0] eaddr,
                          input logic [4:0] etype, input string tag);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1, {tag, " valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_hit == ehit, {tag, " hit"}, 64'(rsp_hit), 64'(ehit));
        check(rsp_addr == eaddr, {tag, " addr"}, rsp_addr, eaddr);
        check(rsp_type == etype, {tag, " type"}, 64'(rsp_type), 64'(etype));
    endtask

    task automatic program_win(input int idx, input logic [63:0] base, input logic [31:0] lim,
                               input logic [63:0] tgt, input logic [31:0] typ, input bit en);
        wr(3'd0, 32'(idx));
        wr(3'd1, base[31:0]);
        wr(3'd2, base[63:32]);
        wr(3'd3, lim);
        wr(3'd4, tgt[31:0]);
        wr(3'd5, tgt[63:32]);
        wr(3'd6, typ);
        wr(3'd7, {31'd0, en});
    endtask

    task automatic t_reset;
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check(rsp_hit == 1'b0, "R1 rsp_hit after reset", 64'(rsp_hit), 64'd0);
        check(cfg_rvalid == 1'b0, "R1 rvalid after reset", 64'(cfg_rvalid), 64'd0);
        rd_chk(3'd7, 32'd0, "R1 window 0 enable");
        rd_chk(3'd1, 32'd0, "R1 window 0 base");
        xl_chk(64'h0000_0000_0000_0040, 1'b0, 64'h40, 5'd0, "R1 pass-through");
    endtask

    task automatic t_program_readback;
        program_win(0, B0, L0, T0, 32'hFFFF_FFE2, 1'b1);
        rd_chk(3'd1, B0[31:0], "R2 base low");
        rd_chk(3'd2, B0[63:32], "R2 base high");
        rd_chk(3'd3, L0, "R2 limit");
        rd_chk(3'd4, T0[31:0], "R2 target low");
        rd_chk(3'd5, T0[63:32], "R2 target high");
        rd_chk(3'd6, 32'h0000_0002, "R4 type masked to 5 bits");
        wr(3'd7, 32'hFFFF_FFFF);
        rd_chk(3'd7, 32'h0000_0001, "R4 enable bit only");
        rd_chk(3'd0, 32'h0000_0000, "R2 selector readback");
    endtask

    task automatic t_translate;
        xl_chk(B0 + 64'h40, 1'b1, T0 + 64'h40, 5'd2, "R7 offset translation");
        xl_chk(B0, 1'b1, T0, 5'd2, "R6 base hits");
        xl_chk(B0 - 64'd1, 1'b0, B0 - 64'd1, 5'd0, "R6 base-1 misses");
        xl_chk({B0[63:32], L0}, 1'b1, T0 + 64'h0000_FFFF, 5'd2, "R6 limit hits");
        xl_chk({B0[63:32], L0} + 64'd1, 1'b0, {B0[63:32], L0} + 64'd1, 5'd0, "R6 limit+1 misses");
        xl_chk(64'h0000_0002_1000_0010, 1'b0, 64'h0000_0002_1000_0010, 5'd0, "R6 upper word differs");
        xl_chk(64'h0000_0000_9000_0000, 1'b0, 64'h0000_0000_9000_0000, 5'd0, "R9 unmapped address");
    endtask

    task automatic t_disable;
        wr(3'd0, 32'd0);
        wr(3'd7, 32'd0);
        xl_chk(B0 + 64'h40, 1'b0, B0 + 64'h40, 5'd0, "R5 disabled window");
        wr(3'd7, 32'd1);
        xl_chk(B0 + 64'h40, 1'b1, T0 + 64'h40, 5'd2, "R5 re-enabled window");
    endtask

    task automatic t_priority;
        program_win(1, B1, 32'h5000_0FFF, T1, 32'd1, 1'b1);
        program_win(2, B0, 32'h1000_00FF, T2, 32'd4, 1'b1);
        rd_chk(3'd1, B0[31:0], "R2 window 2 base low");
        wr(3'd0, 32'd1);
        rd_chk(3'd1, B1[31:0], "R2 window 1 base low");
        xl_chk(B1 + 64'h10, 1'b1, T1 + 64'h10, 5'd1, "R7 window 1 only");
        xl_chk(B0 + 64'h40, 1'b1, T0 + 64'h40, 5'd2, "R8 lowest index wins");
        wr(3'd0, 32'd0);
        wr(3'd7, 32'd0);
        xl_chk(B0 + 64'h40, 1'b1, T2 + 64'h40, 5'd4, "R8 next window after disable");
        wr(3'd7, 32'd1);
    endtask

    task automatic t_blocked;
        wr(3'd0, 32'h8000_0001);
        rd_chk(3'd0, 32'h8000_0001, "R2 selector with direction");
        wr(3'd1, 32'hDEAD_0000);
        wr(3'd7, 32'd0);
        rd_chk(3'd1, 32'd0, "R3 inbound read zero");
        wr(3'd0, 32'd9);
        wr(3'd3, 32'h0000_0000);
        rd_chk(3'd3, 32'd0, "R3 out-of-range read zero");
        wr(3'd0, 32'd1);
        rd_chk(3'd1, B1[31:0], "R3 base kept");
        rd_chk(3'd3, 32'h5000_0FFF, "R3 limit kept");
        xl_chk(B1 + 64'h20, 1'b1, T1 + 64'h20, 5'd1, "R3 window still live");
    endtask

    task automatic t_latency;
        req_valid = 1'b1; req_addr = B1 + 64'h8;
        @(negedge clk);
        check(rsp_valid == 1'b1 && rsp_addr == T1 + 64'h8, "R10 first of pair",
              rsp_addr, T1 + 64'h8);
        req_addr = 64'h0000_0000_9000_0004;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == 1'b1 && rsp_hit == 1'b0 && rsp_addr == 64'h9000_0004,
              "R10 second of pair", rsp_addr, 64'h9000_0004);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 idle after pair", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_readback();
        t_translate();
        t_disable();
        t_priority();
        t_blocked();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule